// File: doc/BRIEF.md
# Cipher Core Host Register Port

This block sits between a 32-bit host bus and an iterative block-cipher engine. The host writes key words and an input block into write-only registers, then starts an operation through one control word. The block passes the key, the input block, a key-valid level and one-cycle start strobes to the engine. When the engine reports completion, the block captures the 128-bit result, clears the start bit on its own, and can raise an interrupt.

The host either polls the control word until the direction bit reads zero, or waits for the interrupt. A key is replaced by first writing the control word with key-valid low, then loading new key words, then raising key-valid again. Raising key-valid again may be done in the same write that starts an operation. While key expansion is in progress under a valid key, key writes are refused and flagged on the wait output. Every output comes from a flip-flop.

Top module: `crypto_host_port`

## Requirements
- R1: After a synchronous reset, the control word reads 0, and the irq, wait, key-valid and both start outputs are 0.
- R2: A write to word offset i (0..7) lands on key_o[32i+31:32i], and a write to offset 8+j (0..3) lands on data_o[32j+31:32j], one clock after the write. Reads of these offsets return 0.
- R3: The control word at offset 31 stores key-valid in bit 7 and interrupt-enable in bit 6. Bit 1 (decrypt) and bit 0 (encrypt) read back as busy flags. All other bits read 0. Encrypt/decrypt bits are kept only when bit 7 is written as 1.
- R4: A control write with bit 7 set and bit 0 set, while not busy, gives a one-cycle start_enc pulse in the next cycle. The same write with bit 1 set and bit 0 clear gives start_dec instead. If both bits are set, encryption is chosen. While busy, the direction fields of a write are ignored.
- R5: When core_done arrives while busy, the direction bit clears and core_result is captured. Afterwards offset 12+k returns result[32k+31:32k].
- R6: When interrupt-enable is set, irq_o rises one cycle after a completion that is accepted. It falls after any read of offsets 12..15, or after a control write with bit 6 clear. With interrupt-enable clear, irq_o stays 0.
- R7: A key write while key-valid is 1 and core_key_ready is 0 is dropped. wait_o is 1 in the cycle after that write and 0 after any other cycle.
- R8: A control write with bit 7 clear aborts: key_valid_o drops and both direction bits clear. A core_done that arrives later is ignored, so it sets no irq and leaves the result unchanged.
- R9: readdata holds the addressed value in the cycle after a read strobe and is 0 otherwise. Reserved offsets 16..30 read 0. Writes to offsets 12..30 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Word offset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| wait_o | output | 1 | Key write refused during expansion |
| irq_o | output | 1 | Completion interrupt |
| key_o | output | 256 | Key words to the engine |
| data_o | output | 128 | Input block to the engine |
| key_valid_o | output | 1 | Key-valid level |
| start_enc | output | 1 | One-cycle encrypt start |
| start_dec | output | 1 | One-cycle decrypt start |
| core_done | input | 1 | Engine completion pulse |
| core_key_ready | input | 1 | Key expansion finished |
| core_result | input | 128 | Engine result block |

## Verification
Each register effect is due one clock after its strobe:
- register contents, readdata, and the start pulse appear after the clock edge that takes the write or read;
- wait_o and irq_o follow one edge after the triggering write, read or completion.

The bench drives on the falling edge and samples at the next falling edge, so every check lands exactly one register stage after its cause. It also checks that a start pulse has gone by the following falling edge. Completion time depends on the engine model's random latency, so the bench polls the control word until the busy bit clears, and only then compares the result, the interrupt and the readback.

// File: rtl/crypto_host_port.sv
module crypto_host_port #(
  parameter int KEY_WORDS = 8,
  localparam int KIW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              addr,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic                    wait_o,
  output logic                    irq_o,
  output logic [KEY_WORDS*32-1:0] key_o,
  output logic [127:0]            data_o,
  output logic                    key_valid_o,
  output logic                    start_enc,
  output logic                    start_dec,
  input  logic                    core_done,
  input  logic                    core_key_ready,
  input  logic [127:0]            core_result
);
  logic [KEY_WORDS-1:0][31:0] key_w;
  logic [3:0][31:0] data_w, res_w;
  logic kv, ie, enc_b, dec_b;
  logic [31:0] rd_mux;

  wire busy     = enc_b | dec_b;
  wire ctrl_wr  = wr && addr == 5'd31;
  wire key_wr   = wr && addr[4:3] == 2'b00;
  wire key_blk  = kv && !core_key_ready;
  wire done_hit = core_done && busy;
  wire res_rd   = rd && addr[4:2] == 3'b011;

  assign key_o       = key_w;
  assign data_o      = data_w;
  assign key_valid_o = kv;

  always_comb begin
    rd_mux = '0;
    if (addr == 5'd31) rd_mux = {24'b0, kv, ie, 4'b0, dec_b, enc_b};
    else if (addr[4:2] == 3'b011) rd_mux = res_w[addr[1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_w <= '0; data_w <= '0; res_w <= '0;
      kv <= 1'b0; ie <= 1'b0; enc_b <= 1'b0; dec_b <= 1'b0;
      start_enc <= 1'b0; start_dec <= 1'b0;
      wait_o <= 1'b0; irq_o <= 1'b0; rdata <= '0;
    end else begin
      wait_o <= key_wr && key_blk;
      if (key_wr && !key_blk && 32'(addr) < KEY_WORDS) key_w[addr[KIW-1:0]] <= wdata;
      if (wr && addr[4:2] == 3'b010) data_w[addr[1:0]] <= wdata;
      start_enc <= ctrl_wr && wdata[7] && !busy && wdata[0];
      start_dec <= ctrl_wr && wdata[7] && !busy && !wdata[0] && wdata[1];
      if (ctrl_wr) begin
        kv    <= wdata[7];
        ie    <= wdata[6];
        enc_b <= wdata[7] && (busy ? enc_b : wdata[0]);
        dec_b <= wdata[7] && (busy ? dec_b : (wdata[1] && !wdata[0]));
      end
      if (done_hit) begin
        enc_b <= 1'b0;
        dec_b <= 1'b0;
        res_w <= core_result;
      end
      if (done_hit && ie) irq_o <= 1'b1;
      else if (res_rd || (ctrl_wr && !wdata[6])) irq_o <= 1'b0;
      rdata <= rd ? rd_mux : '0;
    end
  end

  assert_start_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(start_enc && start_dec));
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    start_enc |=> !start_enc);
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
    done_hit |=> !(enc_b || dec_b));
  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (res_rd && !done_hit) |=> !irq_o);
  assert_irq_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!ie && !(ctrl_wr && wdata[6])) |=> $stable(irq_o) || !irq_o);
  assert_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (key_wr && kv && !core_key_ready) |=> wait_o);
  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wdata[7]) |=> !key_valid_o && !start_enc && !start_dec);
  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == 32'd0);
endmodule

// File: tb/crypto_host_port_test.sv
module crypto_host_port_test;
  logic clk = 0, rst = 1;
  logic [4:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic wait_o, irq_o, key_valid_o, start_enc, start_dec;
  logic [255:0] key_o;
  logic [127:0] data_o;
  logic core_done, core_key_ready;
  logic [127:0] core_result;

  always #5 clk = ~clk;

  crypto_host_port uut (.clk, .rst, .addr, .wr, .rd, .wdata, .rdata, .wait_o, .irq_o,
    .key_o, .data_o, .key_valid_o, .start_enc, .start_dec, .core_done,
    .core_key_ready, .core_result);

  function automatic logic [127:0] model(input logic dir, input logic [127:0] d,
                                         input logic [255:0] k);
    return dir ? (d ^ k[255:128]) : ({d[63:0], d[127:64]} ^ k[127:0]);
  endfunction

  // engine responder
  logic [7:0] lat = 3, cnt, kcnt;
  logic pend, pdir;
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 0; cnt <= 0; pdir <= 0; core_done <= 0; core_result <= '0;
      kcnt <= 0; core_key_ready <= 0;
    end else begin
      if (!key_valid_o) begin kcnt <= 0; core_key_ready <= 0; end
      else if (kcnt < 6) kcnt <= kcnt + 1;
      else core_key_ready <= 1;
      core_done <= 0;
      if (start_enc || start_dec) begin pend <= 1; cnt <= lat; pdir <= start_dec; end
      else if (pend && core_key_ready) begin
        if (cnt == 0) begin
          pend <= 0; core_done <= 1; core_result <= model(pdir, data_o, key_o);
        end else cnt <= cnt - 1;
      end
    end
  end

  int checks = 0, errors = 0;
  logic [31:0] kb [8];
  logic [31:0] db [4];
  logic [127:0] last_res = '0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_word(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  function automatic logic [255:0] kflat();
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[32*i +: 32] = kb[i];
    return k;
  endfunction

  function automatic logic [127:0] dflat();
    logic [127:0] d;
    for (int i = 0; i < 4; i++) d[32*i +: 32] = db[i];
    return d;
  endfunction

  task automatic read_result(output logic [127:0] r);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin rd_word(5'(12 + i), w); r[32*i +: 32] = w; end
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int n = 0; n < 300; n++) begin
      rd_word(5'd31, c);
      if (c[1:0] == 0) break;
    end
  endtask

  // one complete operation; new key loaded when newkey set
  task automatic run_op(input logic dir, input logic ien, input logic newkey);
    logic [31:0] c, w;
    logic [127:0] r;
    logic [31:0] cw;
    if (newkey) begin
      wr_word(5'd31, {25'b0, ien, 6'b0});
      for (int i = 0; i < 8; i++) begin kb[i] = $urandom; wr_word(5'(i), kb[i]); end
    end
    for (int i = 0; i < 4; i++) begin db[i] = $urandom; wr_word(5'(8 + i), db[i]); end
    chk("R2 key_o", {128'b0, key_o} == {128'b0, kflat()}, 1);
    chk("R2 data_o", data_o, dflat());
    lat = 8'($urandom_range(0, 10));
    cw = {24'b0, 1'b1, ien, 4'b0, dir, !dir};
    wr_word(5'd31, cw);
    chk("R4 start_enc", start_enc, !dir);
    chk("R4 start_dec", start_dec, dir);
    @(negedge clk);
    chk("R4 one-cycle pulse", start_enc | start_dec, 0);
    wait_idle();
    rd_word(5'd31, c);
    chk("R5 busy cleared", c, {24'b0, 1'b1, ien, 6'b0});
    chk("R6 irq after done", irq_o, ien);
    read_result(r);
    last_res = model(dir, dflat(), kflat());
    chk("R5 result", r, last_res);
    chk("R6 irq cleared by result read", irq_o, 0);
    w = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [127:0] r;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    rd_word(5'd31, v);
    chk("R1 ctrl", v, 0);
    chk("R1 outputs", {irq_o, wait_o, key_valid_o, start_enc, start_dec}, 0);
    // R3
    wr_word(5'd31, 32'hFFFF_FF7F);
    rd_word(5'd31, v);
    chk("R3 kv low forces busy bits off", v, 32'h40);
    chk("R3 no start without kv", start_enc | start_dec, 0);
    wr_word(5'd31, 32'h0);
    rd_word(5'd31, v);
    chk("R3 cleared", v, 0);
    // R2 / R9 write-only reads
    for (int i = 0; i < 8; i++) begin kb[i] = $urandom; wr_word(5'(i), kb[i]); end
    for (int i = 0; i < 4; i++) begin db[i] = $urandom; wr_word(5'(8 + i), db[i]); end
    chk("R2 key_o", {128'b0, key_o} == {128'b0, kflat()}, 1);
    chk("R2 data_o", data_o, dflat());
    rd_word(5'd3, v);  chk("R2 key read zero", v, 0);
    rd_word(5'd10, v); chk("R2 data read zero", v, 0);
    rd_word(5'(16 + $urandom_range(0, 14)), v); chk("R9 reserved read zero", v, 0);
    @(negedge clk);
    chk("R9 rdata idle", rdata, 0);
    // R4 both bits: encrypt chosen
    lat = 2;
    wr_word(5'd31, 32'h83);
    chk("R4 both bits picks encrypt", {start_enc, start_dec}, 2'b10);
    wait_idle();
    read_result(r);
    chk("R4 both bits result", r, model(0, dflat(), kflat()));
    // random operations
    for (int n = 0; n < 24; n++)
      run_op(1'($urandom), 1'($urandom), (n % 5) == 0);
    // R7 key write during expansion
    wr_word(5'd31, 32'h0);
    kb[0] = $urandom; wr_word(5'd0, kb[0]);
    wr_word(5'd31, 32'h80);
    wr_word(5'd0, ~kb[0]);
    chk("R7 wait asserted", wait_o, 1);
    chk("R7 key word kept", key_o[31:0], kb[0]);
    @(negedge clk);
    chk("R7 wait one cycle", wait_o, 0);
    repeat (10) @(negedge clk);
    kb[0] = ~kb[0]; wr_word(5'd0, kb[0]);
    chk("R7 accepted after ready", {wait_o, key_o[31:0]}, {1'b0, kb[0]});
    // R6 clear via interrupt-enable
    lat = 1;
    wr_word(5'd31, 32'hC1);
    wait_idle();
    chk("R6 irq set", irq_o, 1);
    wr_word(5'd31, 32'h80);
    chk("R6 irq cleared by enable low", irq_o, 0);
    read_result(last_res);
    // R6 no irq when disabled
    wr_word(5'd31, 32'h82);
    wait_idle();
    chk("R6 no irq when disabled", irq_o, 0);
    read_result(last_res);
    // R8 abort
    lat = 30;
    wr_word(5'd31, 32'hC1);
    repeat (3) @(negedge clk);
    wr_word(5'd31, 32'h40);
    rd_word(5'd31, v);
    chk("R8 abort ctrl", v, 32'h40);
    chk("R8 key_valid dropped", key_valid_o, 0);
    wr_word(5'd31, 32'hC0);
    repeat (50) @(negedge clk);
    chk("R8 late done no irq", irq_o, 0);
    read_result(r);
    chk("R8 result unchanged", r, last_res);
    // R9 writes to result and reserved ignored
    wr_word(5'd12, 32'hDEAD_BEEF);
    wr_word(5'd20, 32'h1234_5678);
    read_result(r);
    chk("R9 result write ignored", r, last_res);
    rd_word(5'd20, v); chk("R9 reserved write ignored", v, 0);
    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd_word(5'd31, v);
    chk("R1 ctrl after reset", v, 0);
    chk("R1 outputs after reset", {irq_o, wait_o, key_valid_o}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule